// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register file that sits between a 32-bit processor bus and a separate LCD display engine. Software writes a control word, two geometry words, a free-form timing word and a subpanel word. The block decodes these into plain configuration pins for the engine: enable, mono, TFT mode, palette load mode, panel width, panel height and subpanel settings. Width and height are written and read back as the value minus one. The block adds one before it drives them out.

The display engine sends single-cycle pulses when a frame finishes, when the palette is loaded and when it detects a sync error. The block records each pulse as a sticky status bit. From these bits and two enable bits it forms one level-sensitive interrupt line. A sync error drives the interrupt whatever the enable bits hold. When a control write changes the enable bit, the block emits a one-cycle pulse so the engine can restart its frame sequence.

The bus is word addressed; the byte offset is four times the word index. Index 0 is control, 1 is geometry X, 2 is geometry Y, 3 is the timing word, 4 is status and 5 is subpanel. A write happens on a clock edge where `wr_en` is high. A read is requested by `rd_en` and the result appears on `rd_data` after that edge. `rd_data` holds until the next read. Nothing on this bus stalls, so it has no back-pressure.

Top module: `lcd_reg_unit`

## Requirements
- R1: A synchronous reset clears every stored field and status bit. After reset: control reads 0xFE000C34, index 1 reads 0x0000000F, index 2 reads 0, index 3 reads 0xFC000000, status and subpanel read 0, `irq` is 0, and `width`/`height` are 1.
- R2: A control write sets enable from bit 0, mono from bit 1, the interrupt enables from bits 4:3 (bit 3 for frame, bit 4 for palette), TFT from bit 7 and the palette load mode from bits 21:20. These values drive the matching output pins. A control read returns these fields at the same positions, the TFT bit again at bit 23, and the constant 0xFE000C34 ORed in.
- R3: Other control bits written are kept only where they fall under 0x01CFF300. A written bit outside that mask and outside the decoded fields (for example bit 6) never reads back.
- R4: A write to index 1 sets `width` to written bits 9:0 plus one and keeps bits 31:10. A read returns the kept upper bits, width minus one in bits 9:0, and bits 3:0 forced to one.
- R5: A write to index 2 sets `height` to written bits 9:0 plus one and keeps bits 31:10. A read returns exactly those stored fields.
- R6: A write to index 3 keeps all 32 bits. A read returns them with bits 31:26 forced to one.
- R7: Event pulses set sticky status bits: frame done at bit 0, sync error at bit 2, palette done at bit 6. Writes to the status index leave them unchanged.
- R8: A write to index 5 keeps only the bits under 0xA1FFFFFF. Both the read and the `subpanel` output show the masked value.
- R9: `irq` is high when frame done is set with interrupt enable bit 3, or when palette done is set with interrupt enable bit 4. It is low otherwise, unless a sync error is set.
- R10: A set sync error status drives `irq` high whatever the enable bits hold.
- R11: `en_toggle` is high for exactly the cycle after a control write that changes enable. A control write that leaves enable unchanged gives no pulse.
- R12: Reads from indices 6 and above return 0, and writes to them change no register.
- R13: `rd_data` shows the value addressed in the cycle where `rd_en` was high, from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_frame | input | 1 | Frame done pulse from engine |
| evt_palette | input | 1 | Palette loaded pulse from engine |
| evt_sync | input | 1 | Sync error pulse from engine |
| enable | output | 1 | Controller enable |
| mono | output | 1 | Monochrome mode |
| tft | output | 1 | TFT panel mode |
| pal_mode | output | 2 | Palette load mode |
| width | output | DIM_W+1 | Panel width in pixels |
| height | output | DIM_W+1 | Panel height in lines |
| subpanel | output | 32 | Masked subpanel settings |
| en_toggle | output | 1 | One-cycle pulse when enable changes |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, ADDR_W = 4 and DIM_W = 10. The 4-bit index gives ten unmapped slots (6 to 15), so the bench can check reads that return zero and writes that are ignored. The 10-bit geometry field lets a bench write of all ones in bits 9:0 reach the largest width, 1024, and read back 0x3FF unchanged.

// File: rtl/lcdr_pkg.sv
package lcdr_pkg;
  localparam int unsigned BUS_W = 32;

  localparam int unsigned IX_CTRL = 0;
  localparam int unsigned IX_GEOX = 1;
  localparam int unsigned IX_GEOY = 2;
  localparam int unsigned IX_TIM  = 3;
  localparam int unsigned IX_STS  = 4;
  localparam int unsigned IX_SUBP = 5;

  localparam logic [BUS_W-1:0] CTRL_KEEP  = 32'h01cf_f300;
  localparam logic [BUS_W-1:0] CTRL_ONES  = 32'hfe00_0c34;
  localparam logic [BUS_W-1:0] GEOX_ONES  = 32'h0000_000f;
  localparam logic [BUS_W-1:0] TIM_ONES   = 32'hfc00_0000;
  localparam logic [BUS_W-1:0] SUBP_KEEP  = 32'ha1ff_ffff;

  localparam int unsigned STS_N = 3;
  localparam int unsigned ST_FRAME = 0;
  localparam int unsigned ST_PAL   = 1;
  localparam int unsigned ST_SYNC  = 2;

  typedef struct packed {
    logic             tft;
    logic [1:0]       pal_mode;
    logic [1:0]       ien;
    logic             mono;
    logic             en;
    logic [BUS_W-1:0] extra;
  } ctrl_t;
endpackage

// File: rtl/lcdr_cfg_regs.sv
module lcdr_cfg_regs
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIM_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wr_data,
  output ctrl_t                  ctrl,
  output logic [DIM_W-1:0]       geox_m1,
  output logic [BUS_W-DIM_W-1:0] geox_hi,
  output logic [DIM_W-1:0]       geoy_m1,
  output logic [BUS_W-DIM_W-1:0] geoy_hi,
  output logic [BUS_W-1:0]       tim,
  output logic [BUS_W-1:0]       subp,
  output logic                   en_toggle
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IX_CTRL);
  localparam logic [ADDR_W-1:0] A_GEOX = ADDR_W'(IX_GEOX);
  localparam logic [ADDR_W-1:0] A_GEOY = ADDR_W'(IX_GEOY);
  localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(IX_TIM);
  localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(IX_SUBP);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      geox_m1   <= '0;
      geox_hi   <= '0;
      geoy_m1   <= '0;
      geoy_hi   <= '0;
      tim       <= '0;
      subp      <= '0;
      en_toggle <= 1'b0;
    end else begin
      en_toggle <= ctrl_wr && (wr_data[0] != ctrl.en);
      if (wr_en) begin
        case (addr)
          A_CTRL: begin
            ctrl.en       <= wr_data[0];
            ctrl.mono     <= wr_data[1];
            ctrl.ien      <= wr_data[4:3];
            ctrl.tft      <= wr_data[7];
            ctrl.pal_mode <= wr_data[21:20];
            ctrl.extra    <= wr_data & CTRL_KEEP;
          end
          A_GEOX: begin
            geox_m1 <= wr_data[DIM_W-1:0];
            geox_hi <= wr_data[BUS_W-1:DIM_W];
          end
          A_GEOY: begin
            geoy_m1 <= wr_data[DIM_W-1:0];
            geoy_hi <= wr_data[BUS_W-1:DIM_W];
          end
          A_TIM:   tim  <= wr_data;
          A_SUBP:  subp <= wr_data & SUBP_KEEP;
          default: ;
        endcase
      end
    end
  end

  // R11
  en_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    en_toggle |-> (ctrl.en != $past(ctrl.en)));

  // R8
  subp_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (subp & ~SUBP_KEEP) == '0);
endmodule

// File: rtl/lcdr_status_irq.sv
module lcdr_status_irq
  import lcdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_N-1:0] evt,
  input  logic [1:0]       ien,
  output logic [STS_N-1:0] sts,
  output logic             irq
);
  for (genvar g = 0; g < STS_N; g++) begin : g_sts
    always_ff @(posedge clk) begin
      if (rst)         sts[g] <= 1'b0;
      else if (evt[g]) sts[g] <= 1'b1;
    end
  end

  assign irq = (sts[ST_FRAME] && ien[0]) ||
               (sts[ST_PAL]   && ien[1]) ||
               sts[ST_SYNC];

  // R10
  sync_irq_chk: assert property (@(posedge clk) disable iff (rst)
    evt[ST_SYNC] |=> irq);

  // R7
  frame_latch_chk: assert property (@(posedge clk) disable iff (rst)
    evt[ST_FRAME] |=> sts[ST_FRAME]);
endmodule

// File: rtl/lcdr_read_port.sv
module lcdr_read_port
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIM_W  = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  ctrl_t                  ctrl,
  input  logic [DIM_W-1:0]       geox_m1,
  input  logic [BUS_W-DIM_W-1:0] geox_hi,
  input  logic [DIM_W-1:0]       geoy_m1,
  input  logic [BUS_W-DIM_W-1:0] geoy_hi,
  input  logic [BUS_W-1:0]       tim,
  input  logic [STS_N-1:0]       sts,
  input  logic [BUS_W-1:0]       subp,
  output logic [BUS_W-1:0]       rd_data
);
  localparam int unsigned MAPPED = IX_SUBP + 1;

  logic [BUS_W-1:0] mux;

  always_comb begin
    mux = '0;
    case (addr)
      ADDR_W'(IX_CTRL): mux = CTRL_ONES | ctrl.extra |
                              (BUS_W'(ctrl.tft) << 23) |
                              (BUS_W'(ctrl.pal_mode) << 20) |
                              (BUS_W'(ctrl.tft) << 7) |
                              (BUS_W'(ctrl.ien) << 3) |
                              (BUS_W'(ctrl.mono) << 1) |
                              BUS_W'(ctrl.en);
      ADDR_W'(IX_GEOX): mux = {geox_hi, geox_m1} | GEOX_ONES;
      ADDR_W'(IX_GEOY): mux = {geoy_hi, geoy_m1};
      ADDR_W'(IX_TIM):  mux = tim | TIM_ONES;
      ADDR_W'(IX_STS):  mux = (BUS_W'(sts[ST_PAL]) << 6) |
                              (BUS_W'(sts[ST_SYNC]) << 2) |
                              BUS_W'(sts[ST_FRAME]);
      ADDR_W'(IX_SUBP): mux = subp;
      default:          mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux;
  end

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (32'(addr) >= MAPPED)) |=> (rd_data == '0));

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit
  import lcdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              evt_frame,
  input  logic              evt_palette,
  input  logic              evt_sync,
  output logic              enable,
  output logic              mono,
  output logic              tft,
  output logic [1:0]        pal_mode,
  output logic [DIM_W:0]    width,
  output logic [DIM_W:0]    height,
  output logic [31:0]       subpanel,
  output logic              en_toggle,
  output logic              irq
);
  ctrl_t                  ctrl;
  logic [DIM_W-1:0]       geox_m1, geoy_m1;
  logic [BUS_W-DIM_W-1:0] geox_hi, geoy_hi;
  logic [BUS_W-1:0]       tim;
  logic [STS_N-1:0]       sts;
  logic [STS_N-1:0]       evt;

  assign evt[ST_FRAME] = evt_frame;
  assign evt[ST_PAL]   = evt_palette;
  assign evt[ST_SYNC]  = evt_sync;

  lcdr_cfg_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .ctrl(ctrl), .geox_m1(geox_m1), .geox_hi(geox_hi),
    .geoy_m1(geoy_m1), .geoy_hi(geoy_hi), .tim(tim), .subp(subpanel),
    .en_toggle(en_toggle)
  );

  lcdr_status_irq u_sts (
    .clk(clk), .rst(rst), .evt(evt), .ien(ctrl.ien), .sts(sts), .irq(irq)
  );

  lcdr_read_port #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .ctrl(ctrl),
    .geox_m1(geox_m1), .geox_hi(geox_hi), .geoy_m1(geoy_m1),
    .geoy_hi(geoy_hi), .tim(tim), .sts(sts), .subp(subpanel),
    .rd_data(rd_data)
  );

  assign enable   = ctrl.en;
  assign mono     = ctrl.mono;
  assign tft      = ctrl.tft;
  assign pal_mode = ctrl.pal_mode;
  assign width    = {1'b0, geox_m1} + (DIM_W+1)'(1);
  assign height   = {1'b0, geoy_m1} + (DIM_W+1)'(1);

  // R4
  width_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (width != '0) && (height != '0));
endmodule

// File: tb/lcd_reg_unit_tb.sv
module lcd_reg_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        evt_frame = 1'b0, evt_palette = 1'b0, evt_sync = 1'b0;
  logic        enable, mono, tft, en_toggle, irq;
  logic [1:0]  pal_mode;
  logic [10:0] width, height;
  logic [31:0] subpanel;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lcd_reg_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .evt_frame(evt_frame),
    .evt_palette(evt_palette), .evt_sync(evt_sync), .enable(enable),
    .mono(mono), .tft(tft), .pal_mode(pal_mode), .width(width),
    .height(height), .subpanel(subpanel), .en_toggle(en_toggle), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    evt_frame = (which == 0); evt_palette = (which == 1); evt_sync = (which == 2);
    @(negedge clk);
    evt_frame = 1'b0; evt_palette = 1'b0; evt_sync = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // {index, write value, expected read}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {4'h0, 32'hffff_ffff, 32'hffff_ffbf},  // R2 R3 all decoded
    {4'h0, 32'h0000_0000, 32'hfe00_0c34},  // R2 cleared
    {4'h0, 32'h0020_00c2, 32'hfea0_0cb6},  // R3 bit 6 dropped
    {4'h1, 32'habcd_e3ff, 32'habcd_e3ff},  // R4 widest
    {4'h1, 32'h0000_1410, 32'h0000_141f},  // R4 low nibble ones
    {4'h2, 32'h0000_0c05, 32'h0000_0c05},  // R5
    {4'h3, 32'h1234_5678, 32'hfe34_5678},  // R6
    {4'h5, 32'hffff_ffff, 32'ha1ff_ffff},  // R8
    {4'h4, 32'hffff_ffff, 32'h0000_0000},  // R7 write ignored
    {4'h6, 32'hffff_ffff, 32'h0000_0000},  // R12
    {4'hf, 32'hffff_ffff, 32'h0000_0000},  // R12
    {4'h3, 32'h0000_0000, 32'hfc00_0000}   // R6 cleared
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(4'h0, r); check("R1 ctrl", r, 32'hfe00_0c34);
    bus_rd(4'h1, r); check("R1 geox", r, 32'h0000_000f);
    bus_rd(4'h2, r); check("R1 geoy", r, 32'h0);
    bus_rd(4'h3, r); check("R1 tim", r, 32'hfc00_0000);
    bus_rd(4'h4, r); check("R1 sts", r, 32'h0);
    bus_rd(4'h5, r); check("R1 subp", r, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 width", 32'(width), 32'd1);
    check("R1 height", 32'(height), 32'd1);

    // R13 table walk: read result taken the cycle after rd_en
    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][67:64], VEC[i][63:32]);
      bus_rd(VEC[i][67:64], r);
      check($sformatf("R13 vec%0d", i), r, VEC[i][31:0]);
    end
    // R12 unmapped writes left earlier registers intact
    bus_rd(4'h5, r); check("R12 subp intact", r, 32'ha1ff_ffff);
    check("R2 mono pin", 32'(mono), 32'd1);
    check("R2 tft pin", 32'(tft), 32'd1);
    check("R2 pal_mode pin", 32'(pal_mode), 32'd2);
    check("R4 width pin", 32'(width), 32'd17);
    check("R5 height pin", 32'(height), 32'd6);
    check("R8 subpanel pin", subpanel, 32'ha1ff_ffff);

    // R9 interrupt enables
    bus_wr(4'h0, 32'h0000_0008);
    pulse(0);
    check("R9 frame irq", 32'(irq), 32'd1);
    bus_wr(4'h0, 32'h0000_0000);
    check("R9 frame masked", 32'(irq), 32'd0);
    pulse(1);
    check("R9 palette masked", 32'(irq), 32'd0);
    bus_wr(4'h0, 32'h0000_0010);
    check("R9 palette irq", 32'(irq), 32'd1);
    bus_wr(4'h0, 32'h0000_0000);
    bus_rd(4'h4, r); check("R7 sts frame+pal", r, 32'h0000_0041);

    // R10 sync error ignores enables
    pulse(2);
    check("R10 sync irq", 32'(irq), 32'd1);
    bus_wr(4'h4, 32'h0000_0000);
    bus_rd(4'h4, r); check("R7 sts after write", r, 32'h0000_0045);

    // R11 enable change pulse
    bus_wr(4'h0, 32'h0000_0001);
    check("R11 pulse on rise", 32'(en_toggle), 32'd1);
    check("R2 enable pin", 32'(enable), 32'd1);
    @(negedge clk); check("R11 pulse one cycle", 32'(en_toggle), 32'd0);
    bus_wr(4'h0, 32'h0000_0001);
    check("R11 no pulse same", 32'(en_toggle), 32'd0);
    bus_wr(4'h0, 32'h0000_0000);
    check("R11 pulse on fall", 32'(en_toggle), 32'd1);

    // R1 reset mid-run clears status and irq
    do_reset();
    check("R1 irq after reset", 32'(irq), 32'd0);
    bus_rd(4'h4, r); check("R1 sts after reset", r, 32'h0);
    check("R1 width after reset", 32'(width), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule